// File: doc/BRIEF.md
# Open-Page Line Burst Read Sequencer

This block turns a read request into a stream of cache-line bursts against a single-bank DRAM with fixed command costs. A request carries a starting byte address and a length in whole 64-byte lines. The block walks the lines in address order. For each line it sends a column command, waits out the access latency and then strobes eight 64-bit data beats. Each beat carries the byte address it belongs to.

The block remembers which 4 KB row is open in the bank. A line that falls in the open row goes straight to its column command. A line in another row first closes the open row with a precharge and then opens the new one. After a request the row is left open. A separate close input forces a precharge while the block is idle.

Two counters expose the cost of the traffic: the busy cycles and the precharge commands. They let line-level timing be compared exactly against the fixed cost model.

Top module: `dram_burst_seq`

## Requirements
- R1: After reset, `req_ready` is high, `beat_valid`, `done` and all command strobes are low, both counters read zero, and no row is open.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the request completes. `done` is high for exactly one cycle, the cycle right after the last data beat.
- R3: Each line produces eight consecutive `beat_valid` cycles. Beat k (k = 0..7) carries `beat_addr` = line base + 8·k. The line base drops the low 6 bits of `req_addr`, and successive lines are 64 bytes apart.
- R4: When no row is open, a line first spends 5 activate cycles. Every line then spends 1 column cycle, 3 latency cycles and 8 data cycles. A 1 KB read (16 lines) from a row start with no row open therefore takes 5 + 16·12 = 197 counted cycles.
- R5: A line in the open row takes exactly 12 cycles, with no activate and no precharge.
- R6: A line in a different row than the open one costs 5 precharge cycles and 5 activate cycles before its column command. The precharge counter rises by one for that line.
- R7: The row index is the byte address shifted right by 12. Crossing a row boundary inside a request triggers R6. A 24 KB read from a row start with no row open issues 5 precharges and 6 activates and takes 4663 cycles.
- R8: After a request ends, its last row stays open, so a following request to that row is a hit.
- R9: A `close_req` pulse while idle, with `req_valid` low and a row open, costs 5 counted precharge cycles and adds 1 to the precharge counter. It leaves no row open. A `close_req` while no row is open changes neither counter.
- R10: `cycle_count` advances by one for every cycle spent in precharge, activate, column, latency or data. It does not advance while idle or in the completion cycle.
- R11: A request with `req_lines` = 0 is ignored: no beat, no `done`, and both counters unchanged.
- R12: `cmd_pre`, `cmd_act` and `cmd_col` each pulse for one cycle at the start of their command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W (32) | Start byte address |
| req_lines | input | LEN_W (16) | Number of 64-byte lines |
| close_req | input | 1 | Force a precharge of the open row while idle |
| cmd_pre | output | 1 | Precharge command strobe |
| cmd_act | output | 1 | Row-open command strobe |
| cmd_col | output | 1 | Column command strobe |
| beat_valid | output | 1 | One 64-bit data beat this cycle |
| beat_addr | output | ADDR_W (32) | Byte address of the current beat |
| done | output | 1 | One-cycle pulse after the last beat |
| cycle_count | output | CNT_W (32) | Busy cycles since reset |
| precharge_count | output | CNT_W (32) | Precharges issued since reset |

## Verification
The bench builds the block with its default parameters: 4 KB rows, 64-byte lines, an 8-byte bus, costs of 5/1/3/5 cycles and a 16-bit length field. With a 16-bit length, a single 384-line request covers six rows, so the multi-row precharge count and the long-run cycle total are reached in one transfer. The small fixed costs keep each line near a dozen cycles, so every beat address is compared in the scoreboard. Unaligned starts, a row crossing in the middle of a request, and both branches of the close input are also reached.

// File: rtl/dram_seq_pkg.sv
// Shared types for the burst sequencer.
// Assumes: one bank, fixed command costs, states encoded in 3 bits.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_ACT  = 3'd2,
        S_COL  = 3'd3,
        S_LAT  = 3'd4,
        S_DATA = 3'd5,
        S_DONE = 3'd6
    } seq_state_t;
endpackage

// File: rtl/line_walker.sv
// Steps through the lines of one request.
// Holds the aligned base address of the current line and the number of lines left.
// Assumes: load and adv never coincide, and LINE_BYTES is a power of two.
module line_walker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int ROW_SHIFT  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic [LEN_W-1:0]        load_lines,
    input  logic                    adv,
    output logic [ADDR_W-1:0]       line_addr,
    output logic [ADDR_W-ROW_SHIFT-1:0] line_row,
    output logic [ADDR_W-ROW_SHIFT-1:0] next_row,
    output logic                    last_line
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = line_addr + ADDR_W'(LINE_BYTES);
    assign line_row  = line_addr[ADDR_W-1:ROW_SHIFT];
    assign next_row  = next_addr[ADDR_W-1:ROW_SHIFT];
    assign last_line = (left_q == LEN_W'(1));

    // Capture an aligned start on load; step one line forward on adv.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            left_q    <= '0;
        end else if (load) begin
            line_addr <= load_addr & ~LINE_MASK;
            left_q    <= load_lines;
        end else if (adv) begin
            line_addr <= next_addr;
            left_q    <= left_q - LEN_W'(1);
        end
    end

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (line_addr[$clog2(LINE_BYTES)-1:0] == '0));
endmodule

// File: rtl/row_tracker.sv
// Remembers the open row of the single bank.
// Assumes: act_done only arrives while no row is open.
module row_tracker #(
    parameter int ROW_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_done,
    input  logic             pre_done,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_valid,
    output logic             row_hit
);
    logic [ROW_W-1:0] row_q;

    assign row_hit = row_valid && (row_q == cmp_row);

    // Open a row at the end of activate; forget it at the end of precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= 1'b0;
            row_q     <= '0;
        end else if (act_done) begin
            row_valid <= 1'b1;
            row_q     <= set_row;
        end else if (pre_done) begin
            row_valid <= 1'b0;
        end
    end

    // R8
    row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !pre_done) |=> row_valid);
endmodule

// File: rtl/seq_fsm.sv
// Command sequencer. A single down-counter times every multi-cycle state.
// Assumes: all costs are at least 1, and row_hit reflects the row to be used next.
module seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int T_ACT = 5,
    parameter int T_COL = 1,
    parameter int T_LAT = 3,
    parameter int T_PRE = 5,
    parameter int BEATS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       close_go,
    input  logic                       row_valid,
    input  logic                       row_hit,
    input  logic                       last_line,
    output logic                       ready,
    output logic                       busy,
    output logic                       enter_pre,
    output logic                       act_done,
    output logic                       pre_done,
    output logic                       line_adv,
    output logic                       beat_valid,
    output logic [$clog2(BEATS)-1:0]   beat_idx,
    output logic                       cmd_pre,
    output logic                       cmd_act,
    output logic                       cmd_col,
    output logic                       done
);
    localparam int M1     = (T_ACT > T_PRE) ? T_ACT : T_PRE;
    localparam int M2     = (M1 > T_LAT) ? M1 : T_LAT;
    localparam int M3     = (M2 > T_COL) ? M2 : T_COL;
    localparam int MAXC   = (M3 > BEATS) ? M3 : BEATS;
    localparam int TMR_W  = $clog2(MAXC + 1);
    localparam int BEAT_W = $clog2(BEATS);

    seq_state_t       state, nxt;
    logic [TMR_W-1:0] tmr;
    logic             closing;
    logic             tmr_zero;

    function automatic logic [TMR_W-1:0] load_for(seq_state_t s);
        case (s)
            S_PRE:   return TMR_W'(T_PRE - 1);
            S_ACT:   return TMR_W'(T_ACT - 1);
            S_COL:   return TMR_W'(T_COL - 1);
            S_LAT:   return TMR_W'(T_LAT - 1);
            S_DATA:  return TMR_W'(BEATS - 1);
            default: return '0;
        endcase
    endfunction

    assign tmr_zero = (tmr == '0);

    // Choose the next state from the current command and the row status.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE: begin
                if (start)
                    nxt = !row_valid ? S_ACT : (row_hit ? S_COL : S_PRE);
                else if (close_go && row_valid)
                    nxt = S_PRE;
            end
            S_PRE:  if (tmr_zero) nxt = closing ? S_IDLE : S_ACT;
            S_ACT:  if (tmr_zero) nxt = S_COL;
            S_COL:  if (tmr_zero) nxt = S_LAT;
            S_LAT:  if (tmr_zero) nxt = S_DATA;
            S_DATA: if (tmr_zero) nxt = last_line ? S_DONE : (row_hit ? S_COL : S_PRE);
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Advance the state, reload the timer on each change, and note a close-only precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            tmr     <= '0;
            closing <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)  tmr <= load_for(nxt);
            else if (!tmr_zero) tmr <= tmr - TMR_W'(1);
            if (state == S_IDLE) closing <= !start;
        end
    end

    assign ready      = (state == S_IDLE);
    assign done       = (state == S_DONE);
    assign busy       = (state != S_IDLE) && (state != S_DONE);
    assign enter_pre  = (nxt == S_PRE) && (state != S_PRE);
    assign act_done   = (state == S_ACT) && tmr_zero;
    assign pre_done   = (state == S_PRE) && tmr_zero;
    assign beat_valid = (state == S_DATA);
    assign line_adv   = (state == S_DATA) && tmr_zero && !last_line;
    assign beat_idx   = BEAT_W'(TMR_W'(BEATS - 1) - tmr);
    assign cmd_pre    = (state == S_PRE) && (tmr == TMR_W'(T_PRE - 1));
    assign cmd_act    = (state == S_ACT) && (tmr == TMR_W'(T_ACT - 1));
    assign cmd_col    = (state == S_COL) && (tmr == TMR_W'(T_COL - 1));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACT) |-> !row_valid);
    // R5
    col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COL) |-> row_valid);
    // R4
    col_to_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COL && tmr_zero) |=> (state == S_LAT));
endmodule

// File: rtl/perf_counters.sv
// Busy-cycle and precharge counters.
// Assumes: counters wrap at 2**CNT_W.
module perf_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             enter_pre,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] precharge_count
);
    // Count busy cycles and precharge entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_count     <= '0;
            precharge_count <= '0;
        end else begin
            if (busy)      cycle_count     <= cycle_count + CNT_W'(1);
            if (enter_pre) precharge_count <= precharge_count + CNT_W'(1);
        end
    end

    // R10
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cycle_count)) |-> (cycle_count == $past(cycle_count) + CNT_W'(1)));
    // R6
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(precharge_count)) |-> (precharge_count == $past(precharge_count) + CNT_W'(1)));
endmodule

// File: rtl/dram_burst_seq.sv
// Top: splits a line-count read into bursts under an open-page policy.
// Assumes: single bank, requests are held off by req_ready, and close_req is honoured only while idle.
module dram_burst_seq #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 32,
    parameter int ROW_BYTES  = 4096,
    parameter int LINE_BYTES = 64,
    parameter int BUS_BYTES  = 8,
    parameter int T_ACT      = 5,
    parameter int T_COL      = 1,
    parameter int T_LAT      = 3,
    parameter int T_PRE      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_lines,
    input  logic              close_req,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic              cmd_col,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              done,
    output logic [CNT_W-1:0]  cycle_count,
    output logic [CNT_W-1:0]  precharge_count
);
    localparam int ROW_SHIFT = $clog2(ROW_BYTES);
    localparam int ROW_W     = ADDR_W - ROW_SHIFT;
    localparam int BEATS     = LINE_BYTES / BUS_BYTES;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int BUS_SHIFT = $clog2(BUS_BYTES);

    logic              start, busy, enter_pre, act_done, pre_done, line_adv;
    logic              row_valid, row_hit, last_line;
    logic [ADDR_W-1:0] line_addr;
    logic [ROW_W-1:0]  line_row, next_row, cmp_row;
    logic [BEAT_W-1:0] beat_idx;

    assign start     = req_valid && req_ready && (req_lines != '0);
    // While idle the incoming row is compared; while bursting, the row of the following line.
    assign cmp_row   = req_ready ? req_addr[ADDR_W-1:ROW_SHIFT] : next_row;
    assign beat_addr = line_addr + (ADDR_W'(beat_idx) << BUS_SHIFT);

    line_walker #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .ROW_SHIFT(ROW_SHIFT)
    ) walk_i (
        .clk(clk), .rst_n(rst_n), .load(start), .load_addr(req_addr),
        .load_lines(req_lines), .adv(line_adv), .line_addr(line_addr),
        .line_row(line_row), .next_row(next_row), .last_line(last_line)
    );

    row_tracker #(.ROW_W(ROW_W)) rows_i (
        .clk(clk), .rst_n(rst_n), .act_done(act_done), .pre_done(pre_done),
        .set_row(line_row), .cmp_row(cmp_row), .row_valid(row_valid), .row_hit(row_hit)
    );

    seq_fsm #(
        .T_ACT(T_ACT), .T_COL(T_COL), .T_LAT(T_LAT), .T_PRE(T_PRE), .BEATS(BEATS)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .close_go(close_req),
        .row_valid(row_valid), .row_hit(row_hit), .last_line(last_line),
        .ready(req_ready), .busy(busy), .enter_pre(enter_pre), .act_done(act_done),
        .pre_done(pre_done), .line_adv(line_adv), .beat_valid(beat_valid),
        .beat_idx(beat_idx), .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
        .done(done)
    );

    perf_counters #(.CNT_W(CNT_W)) perf_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .enter_pre(enter_pre),
        .cycle_count(cycle_count), .precharge_count(precharge_count)
    );

    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_lines != '0) |=> !req_ready);
    // R12
    cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre, cmd_act, cmd_col, beat_valid}));
endmodule

// File: tb/dram_burst_seq_tb.sv
// Scoreboard bench. The driver pushes expected beat addresses; the monitor pops them on each beat.
module dram_burst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_lines = '0;
    logic        close_req = 1'b0;
    logic        cmd_pre, cmd_act, cmd_col, beat_valid, done;
    logic [31:0] beat_addr, cycle_count, precharge_count;

    int checks = 0;
    int fails  = 0;
    int act_seen = 0;
    int done_seen = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    // Bench-side row model.
    bit          m_open = 0;
    logic [19:0] m_row  = '0;

    always #4 clk = ~clk;   // 125 MHz

    dram_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_lines(req_lines), .close_req(close_req),
        .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .done(done),
        .cycle_count(cycle_count), .precharge_count(precharge_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare every beat against the scoreboard queue; count strobes.
    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3: actual beat %h expected none", beat_addr);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (e != beat_addr) begin
                    fails++;
                    $display("FAIL R3: actual beat %h expected %h", beat_addr, e);
                end
            end
        end
        if (rst_n && cmd_act) act_seen++;
        if (rst_n && done) done_seen++;
    end

    // Driver: push expected beats, model the cost, issue the request, then check the deltas.
    task automatic run_req(input string req, input logic [31:0] addr, input int lines);
        int e_cyc = 0, e_pre = 0, e_act = 0;
        logic [31:0] base;
        logic [31:0] c0, p0;
        int a0, d0, wait_n;
        base = addr & 32'hFFFF_FFC0;
        for (int i = 0; i < lines; i++) begin
            logic [31:0] la;
            logic [19:0] r;
            la = base + 32'(i * 64);
            r  = la[31:12];
            if (!m_open) begin e_cyc += 5; e_act++; m_open = 1; end
            else if (r != m_row) begin e_cyc += 10; e_pre++; e_act++; end
            m_row = r;
            e_cyc += 12;
            for (int k = 0; k < 8; k++) exp_q.push_back(la + 32'(k * 8));
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        c0 = cycle_count; p0 = precharge_count; a0 = act_seen; d0 = done_seen;
        req_valid = 1'b1; req_addr = addr; req_lines = 16'(lines);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 ready low while busy"}, req_ready, 0);
        wait_n = 0;
        while (done_seen == d0 && wait_n < 20000 && !finished) begin
            @(negedge clk); wait_n++;
        end
        check({req, " R2 done seen"}, done_seen - d0, 1);
        check({req, " R10 cycle delta"}, cycle_count - c0, e_cyc);
        check({req, " R6 precharge delta"}, precharge_count - p0, e_pre);
        check({req, " R12 activate strobes"}, act_seen - a0, e_act);
        @(negedge clk);
        check({req, " R2 ready back"}, req_ready, 1);
        check({req, " R2 single done"}, done_seen - d0, 1);
        check({req, " R3 queue drained"}, exp_q.size(), 0);
    endtask

    task automatic pulse_close(input string req, input int e_cyc, input int e_pre);
        logic [31:0] c0, p0;
        @(negedge clk);
        c0 = cycle_count; p0 = precharge_count;
        close_req = 1'b1;
        @(negedge clk);
        close_req = 1'b0;
        repeat (8) @(negedge clk);
        check({req, " R9 cycle delta"}, cycle_count - c0, e_cyc);
        check({req, " R9 precharge delta"}, precharge_count - p0, e_pre);
        check({req, " R9 idle after close"}, req_ready, 1);
        if (e_pre != 0) m_open = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", req_ready, 1);
        check("R1 beat_valid", beat_valid, 0);
        check("R1 done", done, 0);
        check("R1 cycle_count", cycle_count, 0);
        check("R1 precharge_count", precharge_count, 0);
        check("R1 strobes", {cmd_pre, cmd_act, cmd_col}, 0);
        rst_n = 1'b1;

        // R4: 1 KB from a row start with no row open
        run_req("R4 1KB", 32'h0000_0000, 16);
        check("R4 total 197", cycle_count, 197);
        check("R4 no precharge", precharge_count, 0);

        // R5 and R8: hit in the row left open
        run_req("R5 hit", 32'h0000_0400, 2);

        // R6: miss to another row
        run_req("R6 miss", 32'h0000_2000, 1);

        // R9: close an open row, then close with none open
        pulse_close("R9 close open", 5, 1);
        pulse_close("R9 close none", 0, 0);

        // R7: 24 KB across six rows from a fresh bank
        begin
            logic [31:0] p0, c0;
            p0 = precharge_count; c0 = cycle_count;
            run_req("R7 24KB", 32'h0000_3000, 384);
            check("R7 five precharges", precharge_count - p0, 5);
            check("R7 4663 cycles", cycle_count - c0, 4663);
        end

        // R3/R7: unaligned start on the last line of the open row, crossing into the next row
        run_req("R7 cross", 32'h0000_8FD5, 2);

        // R11: zero-length request is ignored
        begin
            logic [31:0] c0, p0;
            int d0;
            @(negedge clk);
            c0 = cycle_count; p0 = precharge_count; d0 = done_seen;
            req_valid = 1'b1; req_addr = 32'h0000_1000; req_lines = 16'd0;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            check("R11 no cycles", cycle_count - c0, 0);
            check("R11 no precharge", precharge_count - p0, 0);
            check("R11 no done", done_seen - d0, 0);
            check("R11 ready", req_ready, 1);
        end

        // R8: the row is still open after the ignored request
        run_req("R8 still open", 32'h0000_9040, 1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule